// File: doc/BRIEF.md
# Calendar Alarm and Watchdog Supervisor

This block sits beside a battery-backed calendar and watches two things. The first is the current time of day, which the calendar presents as five BCD bytes (second, minute, hour, date, month). The second is a software watchdog that firmware must service. An alarm fires on a one-second tick when the programmed time matches the current time. A per-field wildcard bit lets the alarm repeat every second, every minute, every hour and so on. The watchdog counts a programmed number of slow timebase ticks. When it expires, a steering bit sends the event either to a fixed-length reset pulse or to a held interrupt.

Every event is collected in one flags byte. Reading that byte clears the event flags and releases the interrupt. A supply-fault input blocks all register writes while it is high and leaves a sticky status flag behind.

Software reaches the block through a single-cycle register port. The port never stalls, so it has no valid/ready handshake and no back-pressure. A write with `wr_en_i` high takes effect at the next clock edge. A read returns data combinationally in the same cycle that `rd_en_i` is high. The clear-on-read of the flags byte takes effect at the clock edge that ends that read cycle.

Top module: `aws_supervisor`

## Requirements
- R1: On a cycle with `sec_tick_i` high, if all five alarm fields match the corresponding `tod_i` bytes, the alarm flag (flags bit 6) is set at the next clock edge. A field matches when its bits 6:0, with a zero added above, equal the time byte. The time bytes sit in `tod_i` as second [7:0], minute [15:8], hour [23:16], date [31:24] and month [39:32].
- R2: When bit 7 of an alarm byte is set, that field matches any time value.
- R3: The watchdog byte holds three fields: bit 7 is the steering bit, bits 6:2 are the multiplier M, and bits 1:0 are the resolution code N. Expiry comes after M·4^N pulses of `fast_tick_i`, counted from the last reload. A fast tick runs at 1/16 s, so the codes give 1/16 s, 1/4 s, 1 s and 4 s per count. When M = 0 the watchdog never expires.
- R4: The watchdog count reloads when the watchdog byte is written or when `wd_kick_i` is pulsed. A kick in the same cycle as the final fast tick prevents the expiry. The count also reloads automatically after each expiry.
- R5: Each expiry sets the watchdog flag (flags bit 7) whatever the steering bit is.
- R6: `irq_o` is high while the alarm flag is set, or after an expiry with the steering bit at 0. It stays high until the flags byte is read.
- R7: An expiry with the steering bit at 1 drives `wd_rst_o` high for exactly RST_LEN cycles (default 8) and leaves `irq_o` unaffected.
- R8: Reading offset 0 clears the watchdog flag, the alarm flag and the interrupt cause. It clears the supply flag only if `pwr_fail_i` is low. An event in the same cycle as the read takes priority, so its flag remains set afterwards.
- R9: While `pwr_fail_i` is high, writes have no effect on any register, and the supply flag (flags bit 4) is set.
- R10: The register offsets are 0 for flags, 2 to 6 for the alarm second, minute, hour, date and month, and 7 for the watchdog byte. The alarm bytes and the watchdog byte read back as written. Offset 1 and the unused flag bits read as 0.
- R11: After reset, every register and flag is 0, and `irq_o` and `wd_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the read cycle |
| tod_i | input | 40 | Current time as five BCD bytes |
| sec_tick_i | input | 1 | One-second tick |
| fast_tick_i | input | 1 | Watchdog timebase tick (1/16 s) |
| wd_kick_i | input | 1 | Watchdog service strobe |
| pwr_fail_i | input | 1 | Supply out of tolerance |
| irq_o | output | 1 | Held interrupt |
| wd_rst_o | output | 1 | Watchdog reset pulse |

## Verification
A read of the flags byte can land in the same cycle as a new alarm match or a watchdog expiry. That coincidence decides whether an event is lost. The bench provokes it twice. In one case it raises the read strobe together with a matching second tick. In the other it raises the read strobe together with the final fast tick of a one-count watchdog. In both cases the read data must show the old byte, and the following read must show the new flag. A second race, between a kick and the final tick, is driven the same way, and the expected outcome is that no flag is raised.

// File: rtl/aws_pkg.sv
package aws_pkg;
  localparam int unsigned FIELD_N  = 5;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned TOD_W    = FIELD_N * FIELD_W;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned MULT_W   = 5;
  localparam int unsigned CNT_W    = MULT_W + 6;

  localparam logic [ADDR_W-1:0] OFF_FLAGS  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_ALM_LO = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_WDOG   = 3'd7;

  localparam int unsigned FLG_WD = 7;
  localparam int unsigned FLG_AL = 6;
  localparam int unsigned FLG_PF = 4;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [1:0]        res;
  } wd_cfg_t;

  function automatic logic [CNT_W-1:0] wd_load(wd_cfg_t cfg);
    logic [CNT_W-1:0] base;
    base = CNT_W'(cfg.mult);
    return base << {cfg.res, 1'b0};
  endfunction
endpackage

// File: rtl/aws_alarm_cmp.sv
module aws_alarm_cmp #(
  parameter int unsigned NF = 5,
  parameter int unsigned FW = 8
) (
  input  logic [NF*FW-1:0] alm_i,
  input  logic [NF*FW-1:0] tod_i,
  output logic             match_o
);
  logic [NF-1:0] fld_ok;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic [FW-1:0] want;
    assign want      = {1'b0, alm_i[g*FW +: FW-1]};
    assign fld_ok[g] = alm_i[g*FW + FW-1] | (want == tod_i[g*FW +: FW]);
  end

  assign match_o = &fld_ok;
endmodule

// File: rtl/aws_wdog.sv
module aws_wdog #(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reload_i,
  input  logic [CW-1:0] load_i,
  input  logic          en_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = tick_i & en_i & ~reload_i & (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (reload_i) begin
      cnt_q <= load_i;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == CW'(1)) cnt_q <= load_i;
      else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/aws_pulse.sv
module aws_pulse #(
  parameter int unsigned LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned PW = $clog2(LEN + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (trig_i)          left_q <= PW'(LEN);
    else if (left_q != '0)    left_q <= left_q - PW'(1);
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/aws_supervisor.sv
module aws_supervisor
  import aws_pkg::*;
#(
  parameter int unsigned RST_LEN = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic [TOD_W-1:0]    tod_i,
  input  logic                sec_tick_i,
  input  logic                fast_tick_i,
  input  logic                wd_kick_i,
  input  logic                pwr_fail_i,
  output logic                irq_o,
  output logic                wd_rst_o
);
  logic             wen;
  logic             wd_wr;
  logic             flag_rd;
  logic [TOD_W-1:0] alm_q;
  wd_cfg_t          wd_q;
  wd_cfg_t          wd_src;
  logic [CNT_W-1:0] wd_ld;
  logic             wd_expire;
  logic             alm_hit;
  logic             alm_event;
  logic             wdf_q, af_q, pff_q, wdirq_q;

  assign wen     = wr_en_i & ~pwr_fail_i;
  assign wd_wr   = wen & (addr_i == OFF_WDOG);
  assign flag_rd = rd_en_i & (addr_i == OFF_FLAGS);

  // alarm byte registers, one per field
  for (genvar g = 0; g < FIELD_N; g++) begin : g_alm
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(OFF_ALM_LO + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   alm_q[g*FIELD_W +: FIELD_W] <= '0;
      else if (wen && addr_i == OFF) alm_q[g*FIELD_W +: FIELD_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wd_q <= '0;
    else if (wd_wr) wd_q <= wd_cfg_t'(wdata_i);
  end

  aws_alarm_cmp #(.NF(FIELD_N), .FW(FIELD_W)) u_cmp (
    .alm_i   (alm_q),
    .tod_i   (tod_i),
    .match_o (alm_hit)
  );
  assign alm_event = sec_tick_i & alm_hit;

  // a write supplies the new interval in the same cycle it reloads
  assign wd_src = wd_wr ? wd_cfg_t'(wdata_i) : wd_q;
  assign wd_ld  = wd_load(wd_src);

  aws_wdog #(.CW(CNT_W)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (wd_wr | wd_kick_i),
    .load_i   (wd_ld),
    .en_i     (wd_q.mult != '0),
    .tick_i   (fast_tick_i),
    .expire_o (wd_expire)
  );

  aws_pulse #(.LEN(RST_LEN)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (wd_expire & wd_q.steer),
    .pulse_o (wd_rst_o)
  );

  // flags: a new event wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdf_q   <= 1'b0;
      af_q    <= 1'b0;
      pff_q   <= 1'b0;
      wdirq_q <= 1'b0;
    end else begin
      wdf_q   <= wd_expire | (wdf_q & ~flag_rd);
      af_q    <= alm_event | (af_q & ~flag_rd);
      pff_q   <= pwr_fail_i | (pff_q & ~flag_rd);
      wdirq_q <= (wd_expire & ~wd_q.steer) | (wdirq_q & ~flag_rd);
    end
  end

  assign irq_o = af_q | wdirq_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_FLAGS: begin
        rdata_o[FLG_WD] = wdf_q;
        rdata_o[FLG_AL] = af_q;
        rdata_o[FLG_PF] = pff_q;
      end
      OFF_WDOG: rdata_o = wd_q;
      3'd1:     rdata_o = '0;
      default:  rdata_o = alm_q[(32'(addr_i) - 32'(OFF_ALM_LO))*FIELD_W +: FIELD_W];
    endcase
  end
endmodule

// File: rtl/aws_supervisor_chk.sv
module aws_supervisor_chk
  import aws_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic             pwr_fail_i,
  input logic             irq_o,
  input logic             wd_rst_o,
  input logic [TOD_W-1:0] alm_q,
  input wd_cfg_t          wd_q,
  input logic             alm_event,
  input logic             wd_expire,
  input logic             af_q,
  input logic             wdf_q
);
  AST_PF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_fail_i && wr_en_i) |=> ($stable(alm_q) && $stable(wd_q))); // R9

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(rd_en_i && addr_i == OFF_FLAGS)) |=> irq_o); // R6

  AST_ALARM_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_event |=> af_q); // R1

  AST_WD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_q.mult == '0) |-> !wd_expire); // R3

  AST_WD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |=> wdf_q); // R5

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_FLAGS && !alm_event && !wd_expire) |=> (!af_q && !wdf_q)); // R8

  AST_RST_STEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_rst_o) |-> $past(wd_q.steer)); // R7
endmodule

bind aws_supervisor aws_supervisor_chk u_chk (.*);

// File: tb/aws_supervisor_tb.sv
module aws_supervisor_tb_top;
  localparam int RST_LEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [39:0] tod = '0;
  logic        sec_tick = 1'b0, fast_tick = 1'b0, kick = 1'b0, pf = 1'b0;
  logic        irq, wrst;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aws_supervisor #(.RST_LEN(RST_LEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tod_i(tod), .sec_tick_i(sec_tick),
    .fast_tick_i(fast_tick), .wd_kick_i(kick), .pwr_fail_i(pf),
    .irq_o(irq), .wd_rst_o(wrst));

  // behavioural reference model
  int m_alm[5];
  int m_wd, m_cnt, m_rst;
  bit m_wdf, m_af, m_pff, m_wdirq;

  function automatic int ld_of(int b);
    return ((b >> 2) & 31) * (1 << (2 * (b & 3)));
  endfunction

  function automatic int m_read(int a);
    if (a == 0) return (m_wdf << 7) | (m_af << 6) | (m_pff << 4);
    if (a == 7) return m_wd;
    if (a >= 2) return m_alm[a-2];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_alm[i]) m_alm[i] = 0;
      m_wd = 0; m_cnt = 0; m_rst = 0;
      m_wdf = 0; m_af = 0; m_pff = 0; m_wdirq = 0;
    end else begin
      bit we, rdf, hit, exp_now, reload;
      int old_wd;
      old_wd = m_wd;
      we  = wr_en && !pf;
      rdf = rd_en && addr == 0;
      hit = sec_tick;
      for (int i = 0; i < 5; i++)
        if (!(m_alm[i] & 128) && (m_alm[i] & 127) != int'(tod[i*8 +: 8])) hit = 0;
      reload  = kick || (we && addr == 7);
      exp_now = fast_tick && ((old_wd >> 2) & 31) != 0 && m_cnt == 1 && !reload;
      if (we && addr >= 2 && addr <= 6) m_alm[addr-2] = wdata;
      if (we && addr == 7) m_wd = wdata;
      if (reload) m_cnt = ld_of(m_wd);
      else if (((old_wd >> 2) & 31) == 0) m_cnt = 0;
      else if (fast_tick) m_cnt = (m_cnt == 1) ? ld_of(old_wd) : (m_cnt > 0 ? m_cnt - 1 : 0);
      if (exp_now && (old_wd & 128)) m_rst = RST_LEN;
      else if (m_rst > 0) m_rst--;
      m_wdf   = exp_now || (m_wdf && !rdf);
      m_af    = hit || (m_af && !rdf);
      m_pff   = pf || (m_pff && !rdf);
      m_wdirq = (exp_now && !(old_wd & 128)) || (m_wdirq && !rdf);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the held outputs
  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 irq vs model", int'(irq), int'(m_af || m_wdirq));
    chk("R7 wd_rst vs model", int'(wrst), int'(m_rst != 0));
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    rd_en = 1; addr = 3'(a);
    #1;
    chk(tag, int'(rdata), exp);
    chk({tag, " model"}, int'(rdata), m_read(a));
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic ftick(int n);
    for (int i = 0; i < n; i++) begin
      fast_tick = 1; @(negedge clk); fast_tick = 0;
    end
  endtask

  task automatic stick();
    sec_tick = 1; @(negedge clk); sec_tick = 0;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi;
    tod = {8'h06, 8'h25, 8'h12, 8'h15, 8'h29};
    idle(3);
    @(negedge clk) rst_n = 1;
    // R11 reset state
    chk("R11 irq", int'(irq), 0);
    chk("R11 rst", int'(wrst), 0);
    rd(0, 8'h00, "R11 flags");
    rd(7, 8'h00, "R11 wdog");
    // R10 map and readback
    wr(2, 8'h30); wr(3, 8'h15); wr(4, 8'h12); wr(5, 8'h25); wr(6, 8'h06);
    rd(2, 8'h30, "R10 sec"); rd(4, 8'h12, "R10 hour"); rd(6, 8'h06, "R10 month");
    rd(1, 8'h00, "R10 offset1");
    // R1 mismatch then match
    stick(); rd(0, 8'h00, "R1 no match");
    tod[7:0] = 8'h30;
    stick();
    chk("R6 irq on alarm", int'(irq), 1);
    rd(0, 8'h40, "R1 alarm flag");
    chk("R8 irq released", int'(irq), 0);
    rd(0, 8'h00, "R8 flags cleared");
    // R2 wildcard second and minute
    wr(2, 8'h80); wr(3, 8'h80);
    tod[15:0] = 16'h4407;
    stick(); rd(0, 8'h40, "R2 repeat match");
    wr(2, 8'h30); wr(3, 8'h15);
    stick(); rd(0, 8'h00, "R2 repeat off");
    // R3/R5: steer 0, mult 2, res 0 -> 2 ticks
    wr(7, 8'h08);
    ftick(1); rd(0, 8'h00, "R3 not yet");
    ftick(1);
    chk("R6 wd irq", int'(irq), 1);
    rd(0, 8'h80, "R5 wd flag");
    // R3 resolution: mult 1, res 1 -> 4 ticks; R4 kick reload
    wr(7, 8'h05);
    ftick(3); kick = 1; @(negedge clk); kick = 0;
    ftick(3); rd(0, 8'h00, "R4 kick reloaded");
    ftick(1); rd(0, 8'h80, "R3 res1 expiry");
    kick = 1; @(negedge clk); kick = 0;
    ftick(3);
    kick = 1; fast_tick = 1; @(negedge clk); kick = 0; fast_tick = 0;
    rd(0, 8'h00, "R4 kick beats final tick");
    // R7 steer 1 reset pulse
    wr(7, 8'h84);
    ftick(1);
    hi = 0;
    for (int i = 0; i < RST_LEN + 4; i++) begin
      if (wrst) hi++;
      @(negedge clk);
    end
    chk("R7 pulse length", hi, RST_LEN);
    chk("R7 no irq", int'(irq), 0);
    wr(7, 8'h00);
    rd(0, 8'h80, "R5 flag with steer 1");
    // R3 disable with multiplier zero
    wr(7, 8'h03);
    ftick(10); rd(0, 8'h00, "R3 mult zero off");
    // R9 supply fault
    pf = 1;
    wr(2, 8'h11); wr(7, 8'h04);
    rd(2, 8'h30, "R9 alarm write blocked");
    rd(7, 8'h03, "R9 wdog write blocked");
    rd(0, 8'h10, "R9 supply flag");
    pf = 0;
    rd(0, 8'h10, "R8 supply flag read");
    rd(0, 8'h00, "R8 supply flag cleared");
    // R8 read coinciding with alarm event
    tod = {8'h06, 8'h25, 8'h12, 8'h15, 8'h30};
    rd_en = 1; addr = 3'd0; sec_tick = 1;
    #1 chk("R8 read shows old", int'(rdata), 8'h00);
    @(negedge clk); rd_en = 0; sec_tick = 0;
    rd(0, 8'h40, "R8 alarm survives read");
    // R8 read coinciding with watchdog expiry
    wr(7, 8'h04);
    rd_en = 1; addr = 3'd0; fast_tick = 1;
    #1 chk("R8 read shows old wd", int'(rdata), 8'h00);
    @(negedge clk); rd_en = 0; fast_tick = 0;
    rd(0, 8'h80, "R8 wd survives read");
    wr(7, 8'h00);
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule